// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block is the receiving end of a master-serial configuration link. It makes its own configuration clock by dividing the system clock into a high phase and a low phase whose lengths are set separately. It holds an active-low init line to clear the external serial memory's address counter. It then takes one data bit on every rising configuration-clock edge until a parameterised number of bits has arrived. After that the configuration clock stays low and done is raised. Done is wired to the memory's chip enable, so raising it shuts the memory off.

A load begins on its own when reset is released, and again on every start pulse given once a load has finished. The received bits come out as bytes, most significant bit first, each marked by a one-cycle valid strobe. An option raises done one configuration-clock period early. With that option set, done rises on the same system edge that takes in the final bit, which stops the data source before the loaded logic wakes up.

Top module: `cfg_serial_loader`

## Requirements
- R1: While rst_n is low and on the first clock after its release, init_n_o is 0 and cfg_clk_o, done_o and byte_valid_o are all 0.
- R2: After reset is released, init_n_o stays low for INIT_CYCLES system clocks. After a start pulse is accepted in the finished state, init_n_o stays low for INIT_CYCLES+1 system clocks. cfg_clk_o stays low whenever init_n_o is low.
- R3: While clocking, cfg_clk_o is high for exactly HIGH_CYCLES system clocks and low for exactly LOW_CYCLES system clocks between rising edges. This includes the low stretch after init_n_o rises and before the first rising edge.
- R4: serial_data_i is sampled at the system clock edge on which cfg_clk_o goes from 0 to 1.
- R5: Each load produces exactly TOTAL_BITS rising edges on cfg_clk_o. After that, cfg_clk_o stays at 0 until the next load.
- R6: Every BYTE_W sampled bits form one byte on byte_o. The first sampled bit goes to bit BYTE_W-1. byte_valid_o is high for one cycle, starting on the edge that samples the last bit of the byte. TOTAL_BITS must be a multiple of BYTE_W.
- R7: With EARLY_DONE=1, done_o rises on the same edge that samples the final bit. With EARLY_DONE=0, done_o rises HIGH_CYCLES+LOW_CYCLES system clocks later, which is one configuration-clock period.
- R8: done_o stays high until a start_i pulse arrives in the finished state. The load that pulse begins clears done_o on the next edge.
- R9: A start_i pulse during the init hold or while clocking has no effect. The load in progress delivers the same pulse count and the same bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it begins a load |
| start_i | input | 1 | One-cycle request to reload once the previous load has finished |
| serial_data_i | input | 1 | Serial bit from the external memory |
| cfg_clk_o | output | 1 | Configuration clock sent to the memory |
| init_n_o | output | 1 | Active-low reset of the memory's address counter |
| done_o | output | 1 | Load complete; drives the memory's chip enable |
| byte_o | output | BYTE_W | Last assembled byte, MSB first |
| byte_valid_o | output | 1 | One-cycle strobe for each new byte_o |

## Verification
The assertions take start_i to be a pulse that is synchronous to clk. They take serial_data_i to change only after the configuration-clock edge that advances the memory, never on the system edge that samples it. They also assume HIGH_CYCLES, LOW_CYCLES and INIT_CYCLES are at least one. The stimulus keeps within these limits. A memory model advances its address on the rising edge of cfg_clk_o, resets it while init_n_o is low, and forces its output to 0 while done is high. Every start pulse is driven for exactly one cycle between clock edges.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_INIT_HOLD = 2'd1,
        ST_CLOCKING  = 2'd2,
        ST_DONE      = 2'd3
    } load_state_e;

endpackage

// File: rtl/cfg_clk_phase.sv
module cfg_clk_phase #(
    parameter int HIGH_CYCLES = 5,
    parameter int LOW_CYCLES  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic mask_rise_i,
    output logic cfg_clk_o,
    output logic rise_o,
    output logic gap_o
);

    localparam int PH_MAX = (HIGH_CYCLES > LOW_CYCLES) ? HIGH_CYCLES : LOW_CYCLES;
    localparam int CW     = $clog2(PH_MAX) + 1;
    localparam logic [CW-1:0] HI_LAST = CW'(HIGH_CYCLES - 1);
    localparam logic [CW-1:0] LO_LAST = CW'(LOW_CYCLES - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
    } phase_t;

    phase_t ph_q, ph_d;

    always_comb begin
        ph_d   = ph_q;
        rise_o = 1'b0;
        gap_o  = 1'b0;
        if (!run_i) begin
            ph_d = '0;
        end else if (ph_q.level) begin
            if (ph_q.cnt == HI_LAST) begin
                ph_d.level = 1'b0;
                ph_d.cnt   = '0;
            end else begin
                ph_d.cnt = ph_q.cnt + 1'b1;
            end
        end else if (ph_q.cnt == LO_LAST) begin
            if (mask_rise_i) begin
                gap_o = 1'b1;
            end else begin
                ph_d.level = 1'b1;
                ph_d.cnt   = '0;
                rise_o     = 1'b1;
            end
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign cfg_clk_o = ph_q.level;

    // Run-length trackers for the phase checks
    logic [CW:0] hi_run_q, lo_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= cfg_clk_o ? hi_run_q + 1'b1 : '0;
            if (cfg_clk_o)                      lo_run_q <= '0;
            else if (lo_run_q < (CW+1)'(LOW_CYCLES)) lo_run_q <= lo_run_q + 1'b1;
        end
    end

    assert_high_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk_o) |-> (hi_run_q == (CW+1)'(HIGH_CYCLES)));

    assert_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk_o) |-> (lo_run_q == (CW+1)'(LOW_CYCLES)));

    assert_quiet_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !cfg_clk_o);

endmodule

// File: rtl/cfg_byte_packer.sv
module cfg_byte_packer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o
);

    localparam int NW = $clog2(BYTE_W);
    localparam logic [NW-1:0] N_LAST = NW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [NW-1:0]     cnt;
        logic [BYTE_W-1:0] word;
        logic              valid;
    } pack_t;

    pack_t pk_q, pk_d;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        pk_d       = pk_q;
        pk_d.valid = 1'b0;
        shifted    = {pk_q.sh[BYTE_W-2:0], bit_i};
        if (clear_i) begin
            pk_d.sh  = '0;
            pk_d.cnt = '0;
        end else if (shift_i) begin
            pk_d.sh = shifted;
            if (pk_q.cnt == N_LAST) begin
                pk_d.word  = shifted;
                pk_d.valid = 1'b1;
                pk_d.cnt   = '0;
            end else begin
                pk_d.cnt = pk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign byte_o  = pk_q.word;
    assign valid_o = pk_q.valid;

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_after_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(shift_i));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int TOTAL_BITS  = 559200,
    parameter int INIT_CYCLES = 16,
    parameter int HIGH_CYCLES = 5,
    parameter int LOW_CYCLES  = 5,
    parameter int EARLY_DONE  = 1,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              serial_data_i,
    output logic              cfg_clk_o,
    output logic              init_n_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o
);

    localparam int BW = $clog2(TOTAL_BITS + 1);
    localparam int IW = $clog2(INIT_CYCLES + 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(TOTAL_BITS - 1);
    localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CYCLES - 1);

    initial begin
        assert_whole_bytes_R6: assert ((TOTAL_BITS % BYTE_W) == 0);
    end

    typedef struct packed {
        load_state_e   state;
        logic          boot;
        logic          last;
        logic          done;
        logic [IW-1:0] init_cnt;
        logic [BW-1:0] bit_cnt;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic rise, gap;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.last = 1'b0;
                if (ctl_q.boot || start_i) begin
                    ctl_d.state    = ST_INIT_HOLD;
                    ctl_d.boot     = 1'b0;
                    ctl_d.init_cnt = '0;
                end
            end
            ST_INIT_HOLD: begin
                if (ctl_q.init_cnt == INIT_LAST) begin
                    ctl_d.state   = ST_CLOCKING;
                    ctl_d.bit_cnt = '0;
                    ctl_d.last    = 1'b0;
                end else begin
                    ctl_d.init_cnt = ctl_q.init_cnt + 1'b1;
                end
            end
            ST_CLOCKING: begin
                if (rise) begin
                    ctl_d.bit_cnt = ctl_q.bit_cnt + 1'b1;
                    if (ctl_q.bit_cnt == BIT_LAST) ctl_d.last = 1'b1;
                end
                if (gap) ctl_d.state = ST_DONE;
            end
            ST_DONE: begin
                if (start_i) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.boot  = 1'b1;
                    ctl_d.last  = 1'b0;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        ctl_d.done = (ctl_d.state == ST_DONE) || ((EARLY_DONE != 0) && ctl_d.last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.boot  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic running, last_q;
    assign running = (ctl_q.state == ST_CLOCKING);
    assign last_q  = ctl_q.last;

    cfg_clk_phase #(
        .HIGH_CYCLES (HIGH_CYCLES),
        .LOW_CYCLES  (LOW_CYCLES)
    ) i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (running),
        .mask_rise_i (last_q),
        .cfg_clk_o   (cfg_clk_o),
        .rise_o      (rise),
        .gap_o       (gap)
    );

    cfg_byte_packer #(
        .BYTE_W (BYTE_W)
    ) i_packer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ctl_q.state == ST_IDLE),
        .shift_i (rise),
        .bit_i   (serial_data_i),
        .byte_o  (byte_o),
        .valid_o (byte_valid_o)
    );

    assign init_n_o = (ctl_q.state == ST_CLOCKING) || (ctl_q.state == ST_DONE);
    assign done_o   = ctl_q.done;

    assert_clk_low_in_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n_o |-> !cfg_clk_o);

    assert_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && gap) |-> (ctl_q.bit_cnt == BW'(TOTAL_BITS)));

    assert_no_clk_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_DONE) |-> !cfg_clk_o);

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_i) |=> (ctl_q.state != ST_IDLE));

    generate
        if (EARLY_DONE != 0) begin : g_early
            assert_done_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(last_q) |-> done_o);
        end else begin : g_late
            assert_done_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(last_q) |-> !done_o);
        end
    endgenerate

endmodule

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;

    localparam int TOTAL = 32;
    localparam int INITC = 4;
    localparam int HIGHC = 3;
    localparam int LOWC  = 2;
    localparam int NLOAD = 4;

    // Stimulus table: pattern per load and where a stray start is poked
    // (0 none, 1 while clocking, 2 during init hold)
    localparam logic [31:0] PATS [NLOAD] = '{32'hA5C3_0FF1, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1E69_B487};
    localparam int          POKE [NLOAD] = '{0, 1, 2, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sdata;
    logic cfg_a, init_a, done_a, valid_a;
    logic cfg_b, init_b, done_b, valid_b;
    logic [7:0] byte_a, byte_b;

    always #5 clk = ~clk;

    cfg_serial_loader #(.TOTAL_BITS(TOTAL), .INIT_CYCLES(INITC), .HIGH_CYCLES(HIGHC),
                        .LOW_CYCLES(LOWC), .EARLY_DONE(1), .BYTE_W(8)) i_cfg_serial_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start), .serial_data_i(sdata),
        .cfg_clk_o(cfg_a), .init_n_o(init_a), .done_o(done_a),
        .byte_o(byte_a), .byte_valid_o(valid_a));

    cfg_serial_loader #(.TOTAL_BITS(TOTAL), .INIT_CYCLES(INITC), .HIGH_CYCLES(HIGHC),
                        .LOW_CYCLES(LOWC), .EARLY_DONE(0), .BYTE_W(8)) i_cfg_serial_loader_late (
        .clk(clk), .rst_n(rst_n), .start_i(start), .serial_data_i(sdata),
        .cfg_clk_o(cfg_b), .init_n_o(init_b), .done_o(done_b),
        .byte_o(byte_b), .byte_valid_o(valid_b));

    // Serial memory model: address cleared by init, advanced on cfg clock rise
    logic [31:0] cur_pat = '0;
    int mem_addr = 0;
    always @(posedge cfg_a or negedge init_a) begin
        if (!init_a) mem_addr <= 0;
        else         mem_addr <= mem_addr + 1;
    end
    assign sdata = (!done_a && mem_addr < TOTAL) ? cur_pat[31 - mem_addr] : 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor sampled between edges
    int cyc = 0, rises = 0, nbytes = 0, phase_err = 0, lo_len = 0, hi_len = 0;
    int last_rise_cyc = 0, da_cyc = 0, db_cyc = 0;
    logic [7:0] got [8];
    logic prev_cfg = 1'b0, prev_da = 1'b0, prev_db = 1'b0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!init_a) begin
            rises = 0; nbytes = 0; phase_err = 0; lo_len = 0; hi_len = 0;
        end else begin
            if (cfg_a && !prev_cfg) begin
                if (lo_len != LOWC) phase_err = phase_err + 1;
                lo_len = 0; hi_len = 1; rises = rises + 1;
                if (rises == TOTAL) last_rise_cyc = cyc;
            end else if (cfg_a) begin
                hi_len = hi_len + 1;
            end else if (prev_cfg) begin
                if (hi_len != HIGHC) phase_err = phase_err + 1;
                hi_len = 0; lo_len = 1;
            end else begin
                lo_len = lo_len + 1;
            end
            if (valid_a && nbytes < 8) begin
                got[nbytes] = byte_a;
                nbytes = nbytes + 1;
            end
        end
        if (done_a && !prev_da) da_cyc = cyc;
        if (done_b && !prev_db) db_cyc = cyc;
        prev_cfg = cfg_a; prev_da = done_a; prev_db = done_b;
        if (cyc == 60000) begin
            n_fail++;
            $display("FAIL R5 watchdog expired actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Counts cycles with init low; start is assumed driven high on entry
    task automatic wait_init(input int poke, input int exp_len, input bit from_start);
        int n = 0;
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            if (from_start && k == 1) begin
                start = 1'b0;
                check(done_a == 1'b0, "R8 done cleared by start", done_a, 0);
            end
            if (poke == 2 && k == 3) start = 1'b1;
            if (poke == 2 && k == 4) start = 1'b0;
            if (init_a) break;
            n++;
        end
        check(n == exp_len, "R2 init low length", n, exp_len);
    endtask

    task automatic verify(input int poke, input string tag);
        int waited = 0;
        if (poke == 1) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_b && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(done_b == 1'b1, "R7 late done reached", done_b, 1);
        repeat (15) @(negedge clk);
        check(rises == TOTAL, "R5 rising edge count", rises, TOTAL);
        check(cfg_a == 1'b0, "R5 clock parked low", cfg_a, 0);
        check(phase_err == 0, "R3 phase lengths", phase_err, 0);
        check(nbytes == TOTAL / 8, "R6 byte count", nbytes, TOTAL / 8);
        for (int k = 0; k < TOTAL / 8; k++)
            check(got[k] == cur_pat[31 - 8*k -: 8], "R4 R6 byte value MSB first",
                  got[k], cur_pat[31 - 8*k -: 8]);
        check(da_cyc == last_rise_cyc, "R7 early done on final edge", da_cyc - last_rise_cyc, 0);
        check(db_cyc - last_rise_cyc == HIGHC + LOWC, "R7 late done one period later",
              db_cyc - last_rise_cyc, HIGHC + LOWC);
        check(done_a == 1'b1, "R8 done held", done_a, 1);
        if (poke != 0) check(rises == TOTAL && nbytes == TOTAL / 8,
                             "R9 stray start ignored", rises, TOTAL);
        if (tag.len() == 0) check(1'b0, "R5 empty tag", 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(init_a == 1'b0,  "R1 init low in reset", init_a, 0);
        check(cfg_a == 1'b0,   "R1 clock low in reset", cfg_a, 0);
        check(done_a == 1'b0,  "R1 done low in reset", done_a, 0);
        check(valid_a == 1'b0, "R1 strobe low in reset", valid_a, 0);

        // Table walk: one load per entry
        for (int i = 0; i < NLOAD; i++) begin
            cur_pat = PATS[i];
            if (i == 0) begin
                rst_n = 1'b1;
                wait_init(POKE[i], INITC, 1'b0);
            end else begin
                start = 1'b1;
                wait_init(POKE[i], INITC + 1, 1'b1);
            end
            verify(POKE[i], "table");
        end

        // Directed: reset in the middle of a load, then a clean load
        cur_pat = 32'hC0DE_5A3C;
        start = 1'b1;
        wait_init(0, INITC + 1, 1'b1);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(init_a == 1'b0 && cfg_a == 1'b0, "R1 mid-load reset outputs", cfg_a, 0);
        check(done_a == 1'b0 && done_b == 1'b0, "R1 mid-load reset done", done_a, 0);
        rst_n = 1'b1;
        wait_init(0, INITC, 1'b0);
        verify(0, "reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule